// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block receives exception events from a cell-processing engine and records each one as a 32-bit entry in a small ring of on-chip entry registers. An entry holds a valid flag, a wrap flag, a set of event flags and a 16-bit channel or index field. The host reads entries through a service port, handles them and then clears them with a write. A level interrupt tells the host that unserviced entries are waiting.

The ring has no fixed length. The host pre-loads a wrap flag into the entry it wants to be last. The writer keeps that flag when it fills the entry, and after writing a wrap-marked entry it returns its pointer to entry 0. If no entry carries the flag, the pointer also returns to entry 0 after the last physical entry. When the entry under the write pointer is still valid, the writer drops the new event, raises a sticky overflow flag and holds its pointer in place.

Events arrive on a valid/ready stream. `ev_ready` is high in every cycle except those in which the host writes an entry, so a host write always has the entry storage to itself. An event is taken in a cycle where both `ev_valid` and `ev_ready` are high. A dropped event still counts as taken. The producer must hold `ev_valid` and its fields steady while `ev_ready` is low.

Top module: `iq_event_queue`

## Requirements
- R1: After reset every entry reads as zero, `irq` and `ovf` are low, and `ev_ready` is high while `hst_wr_en` is low.
- R2: An event written into an entry produces this word: bit 31 valid = 1, bit 23 = `ev_events[0]` (scheduling overrun), bit 21 = `ev_events[1]` (transmit queue full), bit 20 = `ev_events[2]` (underrun), bit 19 = `ev_events[3]` (receive frame), bit 18 = `ev_events[4]` (busy), bit 17 = `ev_events[5]` (transmit buffer), bits 15:0 = `ev_index`.
- R3: Bit 28 (congestion) is 1 only when `ev_pti[1]` is 1 and `ev_cng_en` is 1. Otherwise it is 0.
- R4: Bits 29, 27:24, 22 and 16 are reserved. They always read as zero, whatever the host writes to them.
- R5: When the writer fills an entry, bit 30 (wrap) keeps the value already stored in that entry.
- R6: After each stored event the write pointer moves up by one. It returns to entry 0 after it writes an entry whose wrap bit is set, and also after it writes entry DEPTH-1.
- R7: An event taken while the entry under the pointer has bit 31 set is dropped. That entry stays unchanged, `ovf` goes high one cycle later, and the pointer does not move.
- R8: Once `ovf` is high, it stays high until reset.
- R9: `irq` is high exactly while at least one entry has bit 31 set. Only host writes clear that bit.
- R10: While `hst_wr_en` is high, `ev_ready` is low and the host word, with reserved bits masked, goes into entry `hst_addr`. A read with `hst_rd_en` high returns entry `hst_addr` on `hst_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_events | input | 6 | Event flags, mapped as in R2 |
| ev_pti | input | 3 | Payload-type field of the cell behind the event |
| ev_cng_en | input | 1 | Congestion reporting enabled for this channel |
| ev_index | input | 16 | Channel or index value |
| hst_wr_en | input | 1 | Host entry write |
| hst_rd_en | input | 1 | Host entry read |
| hst_addr | input | ADDR_W | Host entry address |
| hst_wdata | input | 32 | Host write word |
| hst_rdata | output | 32 | Host read word, registered |
| irq | output | 1 | Level interrupt: some entry is valid |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with DEPTH = 8 and first places the wrap flag in entry 4. This gives a five-entry ring inside eight physical entries. A sixth event then hits a still-valid entry 0, which exercises the drop path and the held pointer. The bench then removes the wrap flag and pushes eight events, so the pointer runs through all eight physical entries and returns to entry 0 through the DEPTH-1 limit. Congestion cases cover the PTI bit set and clear, with the enable on and off.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned NUM_EV = 6;

  localparam int BIT_VALID = 31;
  localparam int BIT_WRAP  = 30;
  localparam int BIT_CONG  = 28;

  // bits that hold information; all others are reserved and stored as zero
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'hD0BE_FFFF;

  // word position of each event input bit
  function automatic int ev_pos(input int k);
    case (k)
      0:       ev_pos = 23;
      1:       ev_pos = 21;
      2:       ev_pos = 20;
      3:       ev_pos = 19;
      4:       ev_pos = 18;
      default: ev_pos = 17;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] place_events(input logic [NUM_EV-1:0] ev);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < int'(NUM_EV); k++) w[ev_pos(k)] = ev[k];
    return w;
  endfunction
endpackage

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_we,
  input  logic                hst_re,
  input  logic [ADDR_W-1:0]   hst_addr,
  input  logic [WORD_W-1:0]   hst_wdata,
  output logic [WORD_W-1:0]   hst_rdata,
  input  logic                prod_we,
  input  logic [ADDR_W-1:0]   prod_addr,
  input  logic [WORD_W-1:0]   prod_wdata,
  output logic                slot_valid,
  output logic                slot_wrap,
  output logic [DEPTH-1:0]    valid_vec
);
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (hst_we && hst_addr == ADDR_W'(i))
        mem[i] <= hst_wdata & KEEP_MASK;
      else if (prod_we && prod_addr == ADDR_W'(i))
        mem[i] <= prod_wdata & KEEP_MASK;
    end
    assign valid_vec[i] = mem[i][BIT_VALID];
  end

  always_comb begin
    slot_valid = 1'b0;
    slot_wrap  = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (prod_addr == ADDR_W'(i)) begin
        slot_valid = mem[i][BIT_VALID];
        slot_wrap  = mem[i][BIT_WRAP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hst_rdata <= '0;
    else if (hst_re) begin
      hst_rdata <= '0;
      for (int i = 0; i < int'(DEPTH); i++)
        if (hst_addr == ADDR_W'(i)) hst_rdata <= mem[i];
    end
  end

  AST_PROD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && !hst_we) |=> valid_vec[$past(prod_addr)]) else $error("prod write lost"); // R2
endmodule

// File: rtl/iq_writer.sv
module iq_writer
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [NUM_EV-1:0]   ev_events,
  input  logic [2:0]          ev_pti,
  input  logic                ev_cng_en,
  input  logic [IDX_W-1:0]    ev_index,
  input  logic                hst_busy,
  input  logic                slot_valid,
  input  logic                slot_wrap,
  output logic                prod_we,
  output logic [ADDR_W-1:0]   prod_addr,
  output logic [WORD_W-1:0]   prod_wdata,
  output logic                ovf
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wr_ptr;
  logic              take, drop, cong;
  logic              unused_pti;

  assign unused_pti = ^{ev_pti[2], ev_pti[0]};
  assign ev_ready   = !hst_busy;
  assign take       = ev_valid && ev_ready;
  assign prod_we    = take && !slot_valid;
  assign drop       = take && slot_valid;
  assign cong       = ev_pti[1] && ev_cng_en;
  assign prod_addr  = wr_ptr;

  always_comb begin
    prod_wdata             = place_events(ev_events);
    prod_wdata[BIT_VALID]  = 1'b1;
    prod_wdata[BIT_WRAP]   = slot_wrap;
    prod_wdata[BIT_CONG]   = cong;
    prod_wdata[IDX_W-1:0]  = ev_index;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wr_ptr <= '0;
    else if (prod_we)
      wr_ptr <= (slot_wrap || wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ovf <= 1'b0;
    else if (drop) ovf <= 1'b1;
  end

  AST_DROP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (wr_ptr == $past(wr_ptr))) else $error("pointer moved on drop"); // R7
  AST_DROP_RAISES_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf) else $error("overflow not flagged"); // R7
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && slot_wrap) |=> (wr_ptr == '0)) else $error("no reload after wrap entry"); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf) else $error("overflow flag fell"); // R8
endmodule

// File: rtl/iq_event_queue.sv
module iq_event_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [5:0]        ev_events,
  input  logic [2:0]        ev_pti,
  input  logic              ev_cng_en,
  input  logic [15:0]       ev_index,
  input  logic              hst_wr_en,
  input  logic              hst_rd_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              irq,
  output logic              ovf
);
  logic              prod_we, slot_valid, slot_wrap;
  logic [ADDR_W-1:0] prod_addr;
  logic [31:0]       prod_wdata;
  logic [DEPTH-1:0]  valid_vec;

  iq_writer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_events  (ev_events),
    .ev_pti     (ev_pti),
    .ev_cng_en  (ev_cng_en),
    .ev_index   (ev_index),
    .hst_busy   (hst_wr_en),
    .slot_valid (slot_valid),
    .slot_wrap  (slot_wrap),
    .prod_we    (prod_we),
    .prod_addr  (prod_addr),
    .prod_wdata (prod_wdata),
    .ovf        (ovf)
  );

  iq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_we     (hst_wr_en),
    .hst_re     (hst_rd_en),
    .hst_addr   (hst_addr),
    .hst_wdata  (hst_wdata),
    .hst_rdata  (hst_rdata),
    .prod_we    (prod_we),
    .prod_addr  (prod_addr),
    .prod_wdata (prod_wdata),
    .slot_valid (slot_valid),
    .slot_wrap  (slot_wrap),
    .valid_vec  (valid_vec)
  );

  assign irq = |valid_vec;

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !hst_wr_en) |=> irq) else $error("irq fell without host write"); // R9
  AST_IRQ_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ovf && !$past(ev_valid && ev_ready)) |=> (irq || ovf))
    else $error("stored event gave no irq"); // R9
endmodule

// File: tb/iq_event_queue_bench.sv
module iq_event_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_cng_en = 1'b0, hst_wr_en = 1'b0, hst_rd_en = 1'b0;
  logic [5:0] ev_events = '0;
  logic [2:0] ev_pti = '0;
  logic [15:0] ev_index = '0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic ev_ready, irq, ovf;
  logic [31:0] hst_rdata;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  typedef struct { int addr; logic [31:0] word; } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_event_queue #(.DEPTH(DEPTH), .ADDR_W(AW)) u_iq_event_queue (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_events(ev_events), .ev_pti(ev_pti), .ev_cng_en(ev_cng_en), .ev_index(ev_index),
    .hst_wr_en(hst_wr_en), .hst_rd_en(hst_rd_en), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq), .ovf(ovf));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_err++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected entry word built from the field positions in R2, R3, R5
  function automatic logic [31:0] mk(input logic w, input logic cng,
                                     input logic [5:0] e, input logic [15:0] idx);
    return {1'b1, w, 1'b0, cng, 4'b0, e[0], 1'b0, e[1], e[2], e[3], e[4], e[5], 1'b0, idx};
  endfunction

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_addr = AW'(a); hst_wdata = d;
    #1 chk("R10 ready low in host write", {31'b0, ev_ready}, 32'd0);
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [31:0] d);
    @(negedge clk);
    hst_rd_en = 1'b1; hst_addr = AW'(a);
    @(negedge clk);
    hst_rd_en = 1'b0;
    d = hst_rdata;
  endtask

  // driver: offers one event and pushes the expected entry when it must be stored
  task automatic send_ev(input logic [5:0] e, input logic [2:0] pti, input logic cen,
                         input logic [15:0] idx, input int exp_addr, input logic [31:0] exp_word);
    exp_t x;
    @(negedge clk);
    ev_valid = 1'b1; ev_events = e; ev_pti = pti; ev_cng_en = cen; ev_index = idx;
    @(negedge clk);
    ev_valid = 1'b0;
    if (exp_addr >= 0) begin
      x.addr = exp_addr; x.word = exp_word;
      sbq.push_back(x);
    end
  endtask

  // monitor: pops expected entries, reads them back and clears them
  task automatic drain(input int wrap_slot);
    logic [31:0] d;
    exp_t x;
    while (sbq.size() > 0) begin
      x = sbq.pop_front();
      host_read(x.addr, d);
      chk("R2/R3/R5/R6 entry content", d, x.word);
      host_write(x.addr, (x.addr == wrap_slot) ? 32'h4000_0000 : 32'h0);
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);
    chk("R1 ovf after reset", {31'b0, ovf}, 32'd0);
    chk("R1 ready after reset", {31'b0, ev_ready}, 32'd1);
    host_read(0, d);
    chk("R1 entry zero after reset", d, 32'd0);

    // R4 reserved bits, R9 irq from a host-set valid bit
    host_write(2, 32'hFFFF_FFFF);
    host_read(2, d);
    chk("R4 reserved bits masked", d, 32'hD0BE_FFFF);
    chk("R9 irq with valid entry", {31'b0, irq}, 32'd1);
    host_write(2, 32'h0);
    @(negedge clk);
    chk("R9 irq low when none valid", {31'b0, irq}, 32'd0);

    // ring of five: wrap flag in entry 4
    host_write(4, 32'h4000_0000);
    send_ev(6'b000001, 3'b010, 1'b1, 16'h1111, 0, mk(1'b0, 1'b1, 6'b000001, 16'h1111));
    chk("R9 irq after first event", {31'b0, irq}, 32'd1);
    send_ev(6'b000010, 3'b010, 1'b0, 16'h2222, 1, mk(1'b0, 1'b0, 6'b000010, 16'h2222));
    send_ev(6'b000100, 3'b101, 1'b1, 16'h3333, 2, mk(1'b0, 1'b0, 6'b000100, 16'h3333));
    send_ev(6'b111000, 3'b000, 1'b0, 16'hFFFF, 3, mk(1'b0, 1'b0, 6'b111000, 16'hFFFF));
    send_ev(6'b100000, 3'b111, 1'b1, 16'h0004, 4, mk(1'b1, 1'b1, 6'b100000, 16'h0004));
    chk("R8 no overflow yet", {31'b0, ovf}, 32'd0);

    // R7 pointer back at entry 0, which is still valid
    send_ev(6'b010101, 3'b000, 1'b0, 16'hDEAD, -1, 32'h0);
    chk("R7 ovf raised on drop", {31'b0, ovf}, 32'd1);
    host_read(0, d);
    chk("R7 entry kept on drop", d, mk(1'b0, 1'b1, 6'b000001, 16'h1111));

    drain(4);
    @(negedge clk);
    chk("R9 irq low after service", {31'b0, irq}, 32'd0);
    chk("R8 ovf stays high", {31'b0, ovf}, 32'd1);

    // R6/R7 pointer held at entry 0 after the drop
    send_ev(6'b001001, 3'b010, 1'b1, 16'hABCD, 0, mk(1'b0, 1'b1, 6'b001001, 16'hABCD));
    drain(4);

    // R6 physical end: remove wrap, fill 1..7 then back to 0
    host_write(4, 32'h0);
    for (int i = 1; i <= DEPTH; i++) begin
      int slot;
      slot = i % DEPTH;
      send_ev(6'(i), 3'b000, 1'b0, 16'(16'h0100 + i), slot,
              mk(1'b0, 1'b0, 6'(i), 16'(16'h0100 + i)));
    end
    drain(-1);
    chk("R8 ovf still high at end", {31'b0, ovf}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule